// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block is the device-side status logic of a parallel NOR flash. It runs while an internal program or erase job is in progress. It counts the rising edges of the write strobe inside a command sequence, which the command decoder has already classified. When the count is complete it starts the job, and from then until the job ends it replaces array data on reads with a status byte. That byte carries a toggle bit that inverts on every new read access, a flag for an exceeded pulse limit, and a flag showing whether the sector-erase window is still open. The program and erase engines are outside the block. They are reached through a `busy` output and a `core_done` input.

Reads return `array_data` in mode READ. When a sequence completes, the FSM goes to one of four states. It goes to PROG after 4 pulses with op code program. It goes to WINDOW after 6 pulses with op code sector erase. It goes to ERASE after 6 pulses with op code chip erase. It goes to GUARD after either count if `prot_hit` is set. The transitions out of those states are:
- GUARD returns to READ when its timer expires. The timer is short after a program and long after an erase.
- WINDOW moves to ERASE when the erase time-out expires. A further sector-erase write pulse restarts that time-out.
- PROG and ERASE return to READ on `core_done`.
- PROG and ERASE go to FAIL when the pulse limit runs out.
- FAIL leaves only on `rst_cmd`, and goes to READ.

A program that starts with `blank_ok` low is locked: `core_done` is ignored and the job always ends in FAIL.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is in READ with `busy` low, and a read access returns `array_data` unchanged.
- R2: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low; while `dq_oe` is low, `dq_out` is all zero.
- R3: A program starts on the 4th rising edge of `we_n` with `op_kind`=2'b01; after only 3 such edges, reads still return array data. `op_kind`=2'b00 clears the pulse count.
- R4: A sector erase (`op_kind`=2'b10) or chip erase (2'b11) starts on the 6th rising edge of `we_n`; after 5 edges, reads still return array data.
- R5: Outside READ, a read returns the status byte: bit 6 is the toggle bit, bit 5 is the fail flag, bit 3 is the erase flag, and all other bits are 0. The toggle bit inverts at the start of each read access, meaning the first cycle with `ce_n` and `oe_n` both low after a cycle where either is high. The first access after leaving READ returns 1.
- R6: `core_done` in PROG or ERASE (not locked) returns the block to READ, so the next read returns array data.
- R7: A program with `prot_hit` high keeps `busy` low, returns toggling status for GUARD_PROG_US×CLK_MHZ cycles, then returns to READ.
- R8: An erase with `prot_hit` high keeps `busy` low, returns toggling status for GUARD_ERASE_US×CLK_MHZ cycles, then returns to READ.
- R9: A sector erase first spends WINDOW_US×CLK_MHZ cycles in WINDOW with bit 3 at 0 and `busy` low. A `we_n` rising edge with `op_kind`=2'b10 during the window restarts it. The block then moves to ERASE with bit 3 at 1.
- R10: After PULSE_LIMIT cycles in PROG or ERASE without `core_done`, the block enters FAIL. In FAIL, bit 5 reads 1, the toggle bit keeps inverting, `busy` is low and `core_done` has no effect. Only `rst_cmd` returns the block to READ.
- R11: A program started with `blank_ok` low ignores `core_done` and reaches FAIL when the pulse limit runs out.
- R12: `busy` is high only in PROG and ERASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Write strobe, active low, synchronous sample |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_kind | input | 2 | Decoded sequence kind: 00 none, 01 program, 10 sector erase, 11 chip erase |
| prot_hit | input | 1 | Target sector (or every selected sector) is protected |
| blank_ok | input | 1 | Program target is erased |
| core_done | input | 1 | Engine finished the running job |
| rst_cmd | input | 1 | Reset command sequence recognised |
| array_data | input | DW | Data read from the array |
| dq_out | output | DW | Read data or status byte |
| dq_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Engine run request |

## Verification
The toggle bit is tested with random bursts of one to four reads per job, so a toggle bit that sticks or flips twice per access shows up as a wrong value, not as a plausible one. Sequences stopped one pulse short are run next to complete ones, which separates correct pulse counting from an off-by-one start. Protected program, protected erase and the sector window are sampled shortly before and shortly after their nominal ends, and the window is also sampled after a restart, past the end it would have had without one. The pulse-limit path is run both with `core_done` absent and with `core_done` present on a non-blank program, which tells the lock apart from a plain time-out.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_GUARD,
        ST_WINDOW,
        ST_ERASE,
        ST_FAIL
    } fsm_state_e;

    localparam int unsigned PROG_PULSES  = 4;
    localparam int unsigned ERASE_PULSES = 6;

    localparam int unsigned TOG_BIT  = 6;
    localparam int unsigned FAIL_BIT = 5;
    localparam int unsigned ERS_BIT  = 3;

endpackage

// File: rtl/flash_we_counter.sv
module flash_we_counter
    import flash_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_n,
    input  logic [1:0] op_kind,
    input  logic       enable,
    output logic       we_rise,
    output logic       prog_go,
    output logic       erase_go
);
    localparam int unsigned CW = $clog2(ERASE_PULSES + 1);

    logic          we_q;
    logic [CW-1:0] cnt;
    op_kind_e      op;

    assign op      = op_kind_e'(op_kind);
    assign we_rise = we_n & ~we_q;

    assign prog_go  = enable && we_rise && (op == OP_PROG)
                      && (cnt == CW'(PROG_PULSES - 1));
    assign erase_go = enable && we_rise && ((op == OP_SECT) || (op == OP_CHIP))
                      && (cnt == CW'(ERASE_PULSES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            cnt  <= '0;
        end else begin
            we_q <= we_n;
            if (!enable || op == OP_NONE || prog_go || erase_go)
                cnt <= '0;
            else if (we_rise)
                cnt <= cnt + 1'b1;
        end
    end

    // R4: the pulse count never passes the longest sequence
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(ERASE_PULSES));

endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic active,
    output logic tog
);
    logic rd_en;
    logic rd_q;

    assign rd_en = ~ce_n & ~oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_en;
            if (!active)
                tog <= 1'b0;
            else if (rd_en && !rd_q)
                tog <= ~tog;
        end
    end

endmodule

// File: rtl/flash_status_fsm.sv
module flash_status_fsm
    import flash_stat_pkg::*;
#(
    parameter int unsigned GUARD_PROG_CYC  = 200,
    parameter int unsigned GUARD_ERASE_CYC = 20000,
    parameter int unsigned WINDOW_CYC      = 2000,
    parameter int unsigned PULSE_LIMIT     = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_go,
    input  logic       erase_go,
    input  logic       we_rise,
    input  logic [1:0] op_kind,
    input  logic       prot_hit,
    input  logic       blank_ok,
    input  logic       core_done,
    input  logic       rst_cmd,
    output fsm_state_e state
);
    localparam int unsigned M1 = (GUARD_PROG_CYC > GUARD_ERASE_CYC) ? GUARD_PROG_CYC : GUARD_ERASE_CYC;
    localparam int unsigned M2 = (WINDOW_CYC > PULSE_LIMIT) ? WINDOW_CYC : PULSE_LIMIT;
    localparam int unsigned T_MAX = (M1 > M2) ? M1 : M2;
    localparam int unsigned TW = $clog2(T_MAX + 1);

    fsm_state_e    state_nx;
    logic [TW-1:0] tmr, tmr_nx;
    logic          lock, lock_nx;
    op_kind_e      op;

    assign op = op_kind_e'(op_kind);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
            tmr   <= '0;
            lock  <= 1'b0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
            lock  <= lock_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tmr_nx   = (tmr == '0) ? tmr : tmr - 1'b1;
        lock_nx  = lock;
        unique case (state)
            ST_READ: begin
                lock_nx = 1'b0;
                if (prog_go) begin
                    if (prot_hit) begin
                        state_nx = ST_GUARD;
                        tmr_nx   = TW'(GUARD_PROG_CYC - 1);
                    end else begin
                        state_nx = ST_PROG;
                        tmr_nx   = TW'(PULSE_LIMIT - 1);
                        lock_nx  = !blank_ok;
                    end
                end else if (erase_go) begin
                    if (prot_hit) begin
                        state_nx = ST_GUARD;
                        tmr_nx   = TW'(GUARD_ERASE_CYC - 1);
                    end else if (op == OP_SECT) begin
                        state_nx = ST_WINDOW;
                        tmr_nx   = TW'(WINDOW_CYC - 1);
                    end else begin
                        state_nx = ST_ERASE;
                        tmr_nx   = TW'(PULSE_LIMIT - 1);
                    end
                end
            end
            ST_GUARD: begin
                if (tmr == '0) state_nx = ST_READ;
            end
            ST_WINDOW: begin
                if (we_rise && op == OP_SECT) begin
                    tmr_nx = TW'(WINDOW_CYC - 1);
                end else if (tmr == '0) begin
                    state_nx = ST_ERASE;
                    tmr_nx   = TW'(PULSE_LIMIT - 1);
                end
            end
            ST_PROG, ST_ERASE: begin
                if (core_done && !lock) state_nx = ST_READ;
                else if (tmr == '0)     state_nx = ST_FAIL;
            end
            ST_FAIL: begin
                if (rst_cmd) state_nx = ST_READ;
            end
            default: state_nx = ST_READ;
        endcase
    end

    // R6: an unlocked job ends on core_done
    p_done_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PROG || state == ST_ERASE) && core_done && !lock) |=> state == ST_READ);

    // R11: a locked program never completes through core_done
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && lock) |=> state != ST_READ);

    // R10: the failure state is left only by the reset command
    p_fail_stick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL && !rst_cmd) |=> state == ST_FAIL);

    // R9: a sector-erase write pulse keeps the window open
    p_win_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && we_rise && op == OP_SECT) |=> state == ST_WINDOW);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int unsigned DW             = 8,
    parameter int unsigned CLK_MHZ        = 100,
    parameter int unsigned GUARD_PROG_US  = 2,
    parameter int unsigned GUARD_ERASE_US = 200,
    parameter int unsigned WINDOW_US      = 20,
    parameter int unsigned PULSE_LIMIT    = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [1:0]    op_kind,
    input  logic          prot_hit,
    input  logic          blank_ok,
    input  logic          core_done,
    input  logic          rst_cmd,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          busy
);
    localparam int unsigned GUARD_PROG_CYC  = GUARD_PROG_US * CLK_MHZ;
    localparam int unsigned GUARD_ERASE_CYC = GUARD_ERASE_US * CLK_MHZ;
    localparam int unsigned WINDOW_CYC      = WINDOW_US * CLK_MHZ;

    fsm_state_e    state;
    logic          we_rise, prog_go, erase_go;
    logic          tog;
    logic [DW-1:0] stat;

    flash_we_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n     (we_n),
        .op_kind  (op_kind),
        .enable   (state == ST_READ),
        .we_rise  (we_rise),
        .prog_go  (prog_go),
        .erase_go (erase_go)
    );

    flash_toggle_gen u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .active (state != ST_READ),
        .tog    (tog)
    );

    flash_status_fsm #(
        .GUARD_PROG_CYC  (GUARD_PROG_CYC),
        .GUARD_ERASE_CYC (GUARD_ERASE_CYC),
        .WINDOW_CYC      (WINDOW_CYC),
        .PULSE_LIMIT     (PULSE_LIMIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .we_rise   (we_rise),
        .op_kind   (op_kind),
        .prot_hit  (prot_hit),
        .blank_ok  (blank_ok),
        .core_done (core_done),
        .rst_cmd   (rst_cmd),
        .state     (state)
    );

    always_comb begin
        stat           = '0;
        stat[TOG_BIT]  = tog;
        stat[FAIL_BIT] = (state == ST_FAIL);
        stat[ERS_BIT]  = (state == ST_ERASE);
    end

    assign dq_oe  = ~ce_n & ~oe_n;
    assign busy   = (state == ST_PROG) || (state == ST_ERASE);
    assign dq_out = !dq_oe ? '0 : (state == ST_READ) ? array_data : stat;

    // R2: an undriven bus carries zeros
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> dq_out == '0);

    // R5: each new access outside READ flips the toggle bit
    p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(!ce_n && !oe_n) && state != ST_READ) |=> tog != $past(tog));

    // R12: busy never coincides with the failure flag
    p_busy_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state != ST_FAIL && state != ST_GUARD);

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
    logic [1:0] op_kind = 2'b00;
    logic       prot_hit = 1'b0, blank_ok = 1'b1, core_done = 1'b0, rst_cmd = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe, busy;

    int total = 0;
    int bad   = 0;
    bit tog_m = 1'b0;

    always #5 clk = ~clk;

    flash_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .op_kind(op_kind), .prot_hit(prot_hit), .blank_ok(blank_ok),
        .core_done(core_done), .rst_cmd(rst_cmd), .array_data(array_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    function automatic logic [7:0] stat_byte(bit t, bit f, bit e);
        return {1'b0, t, f, 1'b0, e, 3'b000};
    endfunction

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic we_pulse(logic [1:0] op);
        op_kind = op;
        we_n = 1'b0;
        tick();
        we_n = 1'b1;
        tick();
    endtask

    task automatic run_seq(logic [1:0] op, int n);
        for (int i = 0; i < n; i++) we_pulse(op);
        op_kind = 2'b00;
        tog_m = 1'b0;
    endtask

    task automatic read_chk(string req, logic [7:0] exp);
        logic [7:0] v;
        ce_n = 1'b0; oe_n = 1'b0;
        tick();
        v = dq_out;
        ce_n = 1'b1; oe_n = 1'b1;
        tick();
        chk(req, v, exp);
    endtask

    task automatic read_stat(string req, bit f, bit e);
        tog_m = ~tog_m;
        read_chk(req, stat_byte(tog_m, f, e));
    endtask

    task automatic pulse_done();
        core_done = 1'b1;
        tick();
        core_done = 1'b0;
    endtask

    task automatic pulse_rst();
        rst_cmd = 1'b1;
        tick();
        rst_cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4711);
        tick(4);
        // R1 / R2: reset state
        chk("R1 busy at reset", {7'd0, busy}, 8'd0);
        chk("R2 oe idle", {7'd0, dq_oe}, 8'd0);
        chk("R2 bus zero", dq_out, 8'h00);
        rst_n = 1'b1;
        tick(2);
        array_data = 8'hA5;
        read_chk("R1 read mode data", 8'hA5);
        ce_n = 1'b0;
        tick();
        chk("R2 oe high only ce", {7'd0, dq_oe}, 8'd0);
        chk("R2 bus zero only ce", dq_out, 8'h00);
        ce_n = 1'b1;
        tick();

        // R3: short and full program sequences, random data and read bursts
        for (int k = 0; k < 6; k++) begin
            array_data = 8'($urandom);
            run_seq(2'b01, 3);
            read_chk("R3 three pulses still array", array_data);
            tick();
            run_seq(2'b01, 4);
            chk("R12 busy in program", {7'd0, busy}, 8'd1);
            for (int r = 0; r < 1 + int'($urandom % 4); r++)
                read_stat("R5 program toggle", 1'b0, 1'b0);
            tick(1 + int'($urandom % 30));
            pulse_done();
            chk("R6 busy after done", {7'd0, busy}, 8'd0);
            read_chk("R6 array after program", array_data);
        end

        // R4: chip erase, 5 then 6 pulses
        array_data = 8'h3C;
        run_seq(2'b11, 5);
        read_chk("R4 five pulses still array", 8'h3C);
        tick();
        run_seq(2'b11, 6);
        chk("R12 busy in erase", {7'd0, busy}, 8'd1);
        read_stat("R4 chip erase status", 1'b0, 1'b1);
        read_stat("R5 erase toggle", 1'b0, 1'b1);
        pulse_done();
        read_chk("R6 array after erase", 8'h3C);

        // R9: sector erase window with restart
        run_seq(2'b10, 6);
        chk("R9 no busy in window", {7'd0, busy}, 8'd0);
        read_stat("R9 window flag low", 1'b0, 1'b0);
        tick(1000);
        we_pulse(2'b10);
        op_kind = 2'b00;
        tick(1500);
        read_stat("R9 window kept by restart", 1'b0, 1'b0);
        chk("R9 still no busy", {7'd0, busy}, 8'd0);
        tick(700);
        chk("R9 busy after window", {7'd0, busy}, 8'd1);
        read_stat("R9 erase flag high", 1'b0, 1'b1);
        pulse_done();
        read_chk("R6 array after sector erase", 8'h3C);

        // R7: protected program
        prot_hit = 1'b1;
        run_seq(2'b01, 4);
        chk("R7 no busy protected", {7'd0, busy}, 8'd0);
        read_stat("R7 guard status", 1'b0, 1'b0);
        tick(150);
        read_stat("R7 guard still toggling", 1'b0, 1'b0);
        tick(100);
        read_chk("R7 back to array", 8'h3C);

        // R8: protected chip erase
        run_seq(2'b11, 6);
        chk("R8 no busy protected", {7'd0, busy}, 8'd0);
        read_stat("R8 guard status", 1'b0, 1'b0);
        tick(19800);
        read_stat("R8 guard late", 1'b0, 1'b0);
        tick(400);
        read_chk("R8 back to array", 8'h3C);
        prot_hit = 1'b0;

        // R10: pulse limit reached on chip erase
        run_seq(2'b11, 6);
        read_stat("R10 erase running", 1'b0, 1'b1);
        tick(2900);
        chk("R10 busy before limit", {7'd0, busy}, 8'd1);
        tick(200);
        chk("R10 busy dropped", {7'd0, busy}, 8'd0);
        read_stat("R10 fail flag", 1'b1, 1'b0);
        read_stat("R10 fail toggles", 1'b1, 1'b0);
        pulse_done();
        read_stat("R10 done ignored", 1'b1, 1'b0);
        pulse_rst();
        read_chk("R10 reset command", 8'h3C);

        // R11: non-blank program locks out
        blank_ok = 1'b0;
        run_seq(2'b01, 4);
        tick(20);
        pulse_done();
        chk("R11 done ignored busy", {7'd0, busy}, 8'd1);
        read_stat("R11 still status", 1'b0, 1'b0);
        tick(3100);
        read_stat("R11 fail flag", 1'b1, 1'b0);
        pulse_rst();
        blank_ok = 1'b1;
        read_chk("R11 back to array", 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule